// File: doc/BRIEF.md
# Segment Descriptor Access Checker

This block checks a single memory access against a 64-bit segment descriptor. It also forms the linear address for that access. Each request carries the descriptor, a 32-bit offset, the kind of access (read, write or instruction fetch) and the current privilege level. The block unpacks the split base and limit fields and the attribute byte. It then checks, in order, that the segment is present, that the descriptor type allows this kind of access, that the privilege level is sufficient and that the offset lies inside the segment.

The result appears one clock after the request. A successful access returns the base plus the offset, wrapped to 32 bits. It also returns the descriptor with its accessed flag set, so the caller can write the descriptor back to its table. A failed access returns a fault code, a zero address and the descriptor unchanged.

Table walks, selector decoding, gates, task switching, paging and limit granularity scaling belong to the surrounding logic. The limit is always byte-granular here.

Top module: `seg_access_check`

## Requirements
- R1: `rsp_valid_o` is 1 in the cycle after each cycle with `req_valid_i`=1 and 0 otherwise. With no request, `fault_o`, `lin_addr_o` and `desc_upd_o` hold their values.
- R2: If present bit 47 of the descriptor is 0, fault 1 (not present) is reported. It takes precedence over every other check.
- R3: A present descriptor with bit 44 equal to 0 is a system descriptor and gives fault 2 (type) for every access kind.
- R4: Type rules, with bit 43 as executable, bit 41 as write-enable (data) or read-enable (code), and `kind_i` 0=read, 1=write, 2 or 3=fetch. A write to code gives fault 2. A fetch from data gives fault 2. A write to data with bit 41=0 gives fault 2. A read of code with bit 41=0 gives fault 2.
- R5: For a data segment, with the descriptor privilege in bits 46:45 (0 is most privileged), fault 3 is reported unless `cpl_i` <= descriptor privilege.
- R6: For a code segment, bit 42 is the conforming flag. A conforming segment has no privilege check. A non-conforming fetch needs `cpl_i` equal to the descriptor privilege. A non-conforming read needs `cpl_i` <= descriptor privilege. A failed check gives fault 3.
- R7: The 20-bit limit is {bits 51:48, bits 15:0}. For code, and for data with bit 42=0, an offset above the limit gives fault 4.
- R8: For data with bit 42=1 (expand-down), an offset at or below the limit gives fault 4. Any offset above the limit, up to 0xFFFFFFFF, is valid.
- R9: On success, `lin_addr_o` is the 32-bit base {bits 63:56, bits 39:16} plus the offset, modulo 2^32. On any fault it is 0.
- R10: On success, `desc_upd_o` equals the descriptor with bit 40 (accessed) set. On a fault it equals the descriptor unchanged. No other bit is ever changed.
- R11: When several checks fail, only one fault is reported, in this order: not present, type, privilege, limit.
- R12: While `rst_ni` is low, `rsp_valid_o`, `fault_o`, `lin_addr_o` and `desc_upd_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, one access per cycle |
| desc_i | input | 64 | Segment descriptor for the access |
| offset_i | input | 32 | Offset inside the segment |
| kind_i | input | 2 | Access kind: 0 read, 1 write, 2 or 3 fetch |
| cpl_i | input | 2 | Current privilege level |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| fault_o | output | 3 | 0 none, 1 not present, 2 type, 3 privilege, 4 limit |
| lin_addr_o | output | 32 | Linear address on success, else 0 |
| desc_upd_o | output | 64 | Descriptor to write back |

## Verification
All four results (response strobe, fault code, linear address and updated descriptor) are registered once. They are due exactly one clock after the edge that samples the request. The bench drives each request on a falling edge and drops the strobe on the next falling edge. It compares all outputs there, half a cycle after the capturing edge. Idle cycles after a request are sampled the same way, to confirm that the strobe falls and that the other outputs hold.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  localparam int DESC_W  = 64;
  localparam int ADDR_W  = 32;
  localparam int LIMIT_W = 20;
  localparam int PL_W    = 2;
  localparam int KIND_W  = 2;
  localparam int FAULT_W = 3;

  // attribute bit positions inside the descriptor
  localparam int BIT_ACC   = 40;
  localparam int BIT_RW    = 41;
  localparam int BIT_DIRC  = 42;
  localparam int BIT_EXEC  = 43;
  localparam int BIT_SEG   = 44;
  localparam int BIT_DPL   = 45;
  localparam int BIT_PRES  = 47;
  localparam int BIT_LIMHI = 48;
  localparam int BIT_BASEL = 16;
  localparam int BIT_BASEH = 56;
  localparam int LIMLO_W   = 16;
  localparam int LIMHI_W   = LIMIT_W - LIMLO_W;
  localparam int BASEL_W   = 24;
  localparam int BASEH_W   = ADDR_W - BASEL_W;

  typedef enum logic [FAULT_W-1:0] {
    FLT_NONE   = 3'd0,
    FLT_ABSENT = 3'd1,
    FLT_TYPE   = 3'd2,
    FLT_PRIV   = 3'd3,
    FLT_LIMIT  = 3'd4
  } fault_e;

  typedef struct packed {
    logic [ADDR_W-1:0]  base;
    logic [LIMIT_W-1:0] limit;
    logic               present;
    logic [PL_W-1:0]    dpl;
    logic               is_seg;
    logic               exec;
    logic               dir_conf;
    logic               rw_en;
  } seg_fields_t;
endpackage

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
  import seg_chk_pkg::*;
(
  input  logic [DESC_W-1:0] desc_i,
  output seg_fields_t       fields_o
);
  always_comb begin
    fields_o.base     = {desc_i[BIT_BASEH +: BASEH_W], desc_i[BIT_BASEL +: BASEL_W]};
    fields_o.limit    = {desc_i[BIT_LIMHI +: LIMHI_W], desc_i[0 +: LIMLO_W]};
    fields_o.present  = desc_i[BIT_PRES];
    fields_o.dpl      = desc_i[BIT_DPL +: PL_W];
    fields_o.is_seg   = desc_i[BIT_SEG];
    fields_o.exec     = desc_i[BIT_EXEC];
    fields_o.dir_conf = desc_i[BIT_DIRC];
    fields_o.rw_en    = desc_i[BIT_RW];
  end
endmodule

// File: rtl/seg_perm_check.sv
module seg_perm_check
  import seg_chk_pkg::*;
(
  input  seg_fields_t       fields_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [PL_W-1:0]   cpl_i,
  output logic              type_ok_o,
  output logic              priv_ok_o
);
  logic is_fetch, is_write;

  assign is_fetch = kind_i[1];
  assign is_write = (kind_i == 2'd1);

  always_comb begin
    if (!fields_i.is_seg)
      type_ok_o = 1'b0;
    else if (fields_i.exec)
      type_ok_o = !is_write && (is_fetch || fields_i.rw_en);
    else
      type_ok_o = !is_fetch && (!is_write || fields_i.rw_en);
  end

  always_comb begin
    if (fields_i.exec) begin
      if (fields_i.dir_conf) priv_ok_o = 1'b1;
      else if (is_fetch)     priv_ok_o = (cpl_i == fields_i.dpl);
      else                   priv_ok_o = (cpl_i <= fields_i.dpl);
    end else begin
      priv_ok_o = (cpl_i <= fields_i.dpl);
    end
  end
endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check
  import seg_chk_pkg::*;
(
  input  logic [ADDR_W-1:0]  offset_i,
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic               expand_down_i,
  output logic               in_bounds_o
);
  logic [ADDR_W-1:0] limit_ext;
  logic              above;

  assign limit_ext   = {{(ADDR_W-LIMIT_W){1'b0}}, limit_i};
  assign above       = offset_i > limit_ext;
  // expand-down: valid window is (limit, all-ones]
  assign in_bounds_o = expand_down_i ? above : !above;
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
  import seg_chk_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [DESC_W-1:0]   desc_i,
  input  logic [ADDR_W-1:0]   offset_i,
  input  logic [KIND_W-1:0]   kind_i,
  input  logic [PL_W-1:0]     cpl_i,
  output logic                rsp_valid_o,
  output logic [FAULT_W-1:0]  fault_o,
  output logic [ADDR_W-1:0]   lin_addr_o,
  output logic [DESC_W-1:0]   desc_upd_o
);
  seg_fields_t       fields;
  logic              type_ok, priv_ok, in_bounds;
  fault_e            fault_n;
  logic [ADDR_W-1:0] addr_n;
  logic [DESC_W-1:0] upd_n;

  seg_desc_unpack u_unpack (
    .desc_i   (desc_i),
    .fields_o (fields)
  );

  seg_perm_check u_perm (
    .fields_i  (fields),
    .kind_i    (kind_i),
    .cpl_i     (cpl_i),
    .type_ok_o (type_ok),
    .priv_ok_o (priv_ok)
  );

  seg_limit_check u_limit (
    .offset_i      (offset_i),
    .limit_i       (fields.limit),
    .expand_down_i (!fields.exec && fields.dir_conf),
    .in_bounds_o   (in_bounds)
  );

  // fixed priority: presence, type, privilege, limit
  always_comb begin
    if (!fields.present) fault_n = FLT_ABSENT;
    else if (!type_ok)   fault_n = FLT_TYPE;
    else if (!priv_ok)   fault_n = FLT_PRIV;
    else if (!in_bounds) fault_n = FLT_LIMIT;
    else                 fault_n = FLT_NONE;
  end

  always_comb begin
    addr_n = '0;
    upd_n  = desc_i;
    if (fault_n == FLT_NONE) begin
      addr_n         = fields.base + offset_i;
      upd_n[BIT_ACC] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      fault_o     <= '0;
      lin_addr_o  <= '0;
      desc_upd_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        fault_o    <= fault_n;
        lin_addr_o <= addr_n;
        desc_upd_o <= upd_n;
      end
    end
  end

  assert_rsp_follows_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  assert_no_spurious_rsp_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  assert_hold_when_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(fault_o) && $stable(lin_addr_o) && $stable(desc_upd_o));
  assert_absent_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !desc_i[BIT_PRES] |=> fault_o == 3'd1);
  assert_system_type_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && desc_i[BIT_PRES] && !desc_i[BIT_SEG] |=> fault_o == 3'd2);
  assert_fault_zero_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && fault_o != 3'd0 |-> lin_addr_o == '0);
  assert_upd_other_bits_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> desc_upd_o[DESC_W-1:BIT_ACC+1] == $past(desc_i[DESC_W-1:BIT_ACC+1])
                 && desc_upd_o[BIT_ACC-1:0] == $past(desc_i[BIT_ACC-1:0]));
  assert_accessed_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && fault_o == 3'd0 |-> desc_upd_o[BIT_ACC]);
  assert_fault_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> fault_o <= 3'd4);
endmodule

// File: tb/seg_access_check_test.sv
module seg_access_check_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 32;

  typedef struct packed {
    logic [31:0] base;
    logic [19:0] lim;
    logic [7:0]  acc;
    logic [31:0] off;
    logic [1:0]  kind;
    logic [1:0]  cpl;
    logic [2:0]  flt;
    logic [7:0]  req;
  } vec_t;

  // acc byte: 80 present, 60 privilege, 10 code/data, 08 exec, 04 dir/conf, 02 rw, 01 accessed
  localparam vec_t VECS [NVEC] = '{
    '{32'h0010_0000, 20'h00FFF, 8'h92, 32'h0000_0010, 2'd0, 2'd0, 3'd0, 8'd9 },  // R9 basic read
    '{32'h0010_0000, 20'h00FFF, 8'h92, 32'h0000_0FFF, 2'd1, 2'd0, 3'd0, 8'd7 },  // R7 at limit
    '{32'h0010_0000, 20'h00FFF, 8'h92, 32'h0000_1000, 2'd0, 2'd0, 3'd4, 8'd7 },  // R7 past limit
    '{32'h0010_0000, 20'h00FFF, 8'h90, 32'h0000_0010, 2'd1, 2'd0, 3'd2, 8'd4 },  // R4 read-only write
    '{32'h0010_0000, 20'h00FFF, 8'h90, 32'h0000_0010, 2'd0, 2'd0, 3'd0, 8'd4 },  // R4 read-only read
    '{32'h0010_0000, 20'h00FFF, 8'h92, 32'h0000_0010, 2'd2, 2'd0, 3'd2, 8'd4 },  // R4 fetch data
    '{32'h0010_0000, 20'h00FFF, 8'h92, 32'h0000_0010, 2'd3, 2'd0, 3'd2, 8'd4 },  // R4 kind 3 fetch
    '{32'h0010_0000, 20'h00FFF, 8'h12, 32'h0000_0010, 2'd0, 2'd0, 3'd1, 8'd2 },  // R2 absent
    '{32'h0010_0000, 20'h00FFF, 8'h82, 32'h0000_0010, 2'd0, 2'd0, 3'd2, 8'd3 },  // R3 system read
    '{32'h0010_0000, 20'h00FFF, 8'h89, 32'h0000_0010, 2'd2, 2'd0, 3'd2, 8'd3 },  // R3 system fetch
    '{32'h0010_0000, 20'h00FFF, 8'h92, 32'h0000_0010, 2'd0, 2'd3, 3'd3, 8'd5 },  // R5 cpl3 dpl0
    '{32'h0010_0000, 20'h00FFF, 8'hB2, 32'h0000_0010, 2'd1, 2'd2, 3'd3, 8'd5 },  // R5 cpl2 dpl1
    '{32'h0010_0000, 20'h00FFF, 8'hF2, 32'h0000_0010, 2'd0, 2'd3, 3'd0, 8'd5 },  // R5 equal
    '{32'h0010_0000, 20'h00FFF, 8'hF2, 32'h0000_0010, 2'd1, 2'd0, 3'd0, 8'd5 },  // R5 more privileged
    '{32'h0020_0000, 20'h00FFF, 8'h9A, 32'h0000_0010, 2'd1, 2'd0, 3'd2, 8'd4 },  // R4 write code
    '{32'h0020_0000, 20'h00FFF, 8'h98, 32'h0000_0010, 2'd0, 2'd0, 3'd2, 8'd4 },  // R4 read exec-only
    '{32'h0020_0000, 20'h00FFF, 8'h98, 32'h0000_0010, 2'd2, 2'd0, 3'd0, 8'd4 },  // R4 fetch exec-only
    '{32'h0020_0000, 20'h00FFF, 8'h9A, 32'h0000_0010, 2'd2, 2'd3, 3'd3, 8'd6 },  // R6 nonconf cpl3
    '{32'h0020_0000, 20'h00FFF, 8'hFA, 32'h0000_0010, 2'd2, 2'd0, 3'd3, 8'd6 },  // R6 nonconf cpl0 dpl3
    '{32'h0020_0000, 20'h00FFF, 8'hFA, 32'h0000_0010, 2'd2, 2'd3, 3'd0, 8'd6 },  // R6 nonconf equal
    '{32'h0020_0000, 20'h00FFF, 8'hFA, 32'h0000_0010, 2'd0, 2'd0, 3'd0, 8'd6 },  // R6 nonconf read le
    '{32'h0020_0000, 20'h00FFF, 8'h9E, 32'h0000_0010, 2'd2, 2'd3, 3'd0, 8'd6 },  // R6 conforming fetch
    '{32'h0020_0000, 20'h00FFF, 8'h9E, 32'h0000_0010, 2'd0, 2'd3, 3'd0, 8'd6 },  // R6 conforming read
    '{32'h0020_0000, 20'h00FFF, 8'h9E, 32'h0000_2000, 2'd2, 2'd0, 3'd4, 8'd7 },  // R7 code up-limit
    '{32'h0030_0000, 20'h00FFF, 8'h96, 32'h0000_0FFF, 2'd0, 2'd0, 3'd4, 8'd8 },  // R8 at limit
    '{32'h0030_0000, 20'h00FFF, 8'h96, 32'h0000_1000, 2'd1, 2'd0, 3'd0, 8'd8 },  // R8 above limit
    '{32'h0030_0000, 20'h00FFF, 8'h96, 32'hFFFF_FFFF, 2'd0, 2'd0, 3'd0, 8'd8 },  // R8 top
    '{32'h0010_0000, 20'h00FFF, 8'h10, 32'h0000_2000, 2'd1, 2'd3, 3'd1, 8'd11},  // R11 absent first
    '{32'h0010_0000, 20'h00FFF, 8'h90, 32'h0000_2000, 2'd1, 2'd3, 3'd2, 8'd11},  // R11 type before priv
    '{32'h0010_0000, 20'h00FFF, 8'h92, 32'h0000_2000, 2'd0, 2'd3, 3'd3, 8'd11},  // R11 priv before limit
    '{32'hFFFF_FF00, 20'hFFFFF, 8'h93, 32'h0000_0200, 2'd0, 2'd0, 3'd0, 8'd9 },  // R9 wrap, A already set
    '{32'h1234_5678, 20'hA1234, 8'h92, 32'h000A_1235, 2'd0, 2'd0, 3'd4, 8'd7 }   // R7 high limit bits
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [63:0] desc_i = '0;
  logic [31:0] offset_i = '0;
  logic [1:0]  kind_i = '0;
  logic [1:0]  cpl_i = '0;
  logic        rsp_valid_o;
  logic [2:0]  fault_o;
  logic [31:0] lin_addr_o;
  logic [63:0] desc_upd_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_access_check uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .desc_i      (desc_i),
    .offset_i    (offset_i),
    .kind_i      (kind_i),
    .cpl_i       (cpl_i),
    .rsp_valid_o (rsp_valid_o),
    .fault_o     (fault_o),
    .lin_addr_o  (lin_addr_o),
    .desc_upd_o  (desc_upd_o)
  );

  function automatic logic [63:0] mk_desc(logic [31:0] b, logic [19:0] l, logic [7:0] a);
    return {b[31:24], 4'h0, l[19:16], a, b[23:0], l[15:0]};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive on falling edge, result due after next rising edge, sampled on following falling edge
  task automatic access(logic [63:0] d, logic [31:0] o, logic [1:0] k, logic [1:0] c);
    @(negedge clk);
    desc_i = d; offset_i = o; kind_i = k; cpl_i = c; req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [63:0] exp_upd;
    logic [31:0] exp_addr;

    // R12 reset state
    #(CLK_PERIOD * 2 + 1);
    chk("R12 rsp_valid", 64'(rsp_valid_o), 64'd0);
    chk("R12 fault", 64'(fault_o), 64'd0);
    chk("R12 addr", 64'(lin_addr_o), 64'd0);
    chk("R12 desc", desc_upd_o, 64'd0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 idle no rsp", 64'(rsp_valid_o), 64'd0);

    for (int i = 0; i < NVEC; i++) begin
      d = mk_desc(VECS[i].base, VECS[i].lim, VECS[i].acc);
      access(d, VECS[i].off, VECS[i].kind, VECS[i].cpl);
      exp_addr = (VECS[i].flt == 3'd0) ? VECS[i].base + VECS[i].off : 32'd0;
      exp_upd  = (VECS[i].flt == 3'd0) ? (d | (64'd1 << 40)) : d;
      chk($sformatf("R%0d vec %0d rsp", VECS[i].req, i), 64'(rsp_valid_o), 64'd1);
      chk($sformatf("R%0d vec %0d fault", VECS[i].req, i), 64'(fault_o), 64'(VECS[i].flt));
      chk($sformatf("R9 vec %0d addr", i), 64'(lin_addr_o), 64'(exp_addr));
      chk($sformatf("R10 vec %0d desc", i), desc_upd_o, exp_upd);
    end

    // R1 idle cycle: strobe low, outputs held from last vector
    d = mk_desc(32'h1234_5678, 20'hA1234, 8'h92);
    access(d, 32'h000A_1234, 2'd0, 2'd0);
    chk("R7 high limit at bound", 64'(fault_o), 64'd0);
    chk("R9 addr split base", 64'(lin_addr_o), 64'(32'h1234_5678 + 32'h000A_1234));
    desc_i = '0; offset_i = '0; kind_i = 2'd1;
    @(negedge clk);
    chk("R1 idle strobe low", 64'(rsp_valid_o), 64'd0);
    chk("R1 fault held", 64'(fault_o), 64'd0);
    chk("R1 addr held", 64'(lin_addr_o), 64'(32'h1234_5678 + 32'h000A_1234));
    chk("R10 desc held", desc_upd_o, d | (64'd1 << 40));

    // R1 back-to-back requests
    @(negedge clk);
    desc_i = mk_desc(32'h0, 20'h00FFF, 8'h12); offset_i = 32'h10; kind_i = 2'd0; cpl_i = 2'd0;
    req_valid_i = 1'b1;
    @(negedge clk);
    chk("R1 b2b first rsp", 64'(rsp_valid_o), 64'd1);
    chk("R2 b2b first fault", 64'(fault_o), 64'd1);
    desc_i = mk_desc(32'h0000_4000, 20'h00FFF, 8'h92); offset_i = 32'h20;
    @(negedge clk);
    req_valid_i = 1'b0;
    chk("R1 b2b second rsp", 64'(rsp_valid_o), 64'd1);
    chk("R9 b2b second addr", 64'(lin_addr_o), 64'h4020);

    // R12 reset mid-run clears outputs
    rst_ni = 1'b0;
    #1;
    chk("R12 async reset fault", 64'(fault_o), 64'd0);
    chk("R12 async reset addr", 64'(lin_addr_o), 64'd0);
    chk("R12 async reset desc", desc_upd_o, 64'd0);
    @(negedge clk); rst_ni = 1'b1;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule